// File: doc/BRIEF.md
# Posted Column Command Delay Pipeline

This block sits behind the command decoder of a DDR3-style memory device model and handles posted column commands. A read or write, with or without an auto-precharge tag, is taken from the bus on the clock edge where it is strobed. It is then held for the additive latency before it is launched to the internal core. The block also marks the clock cycles where read data leaves the device and the cycles where write data must arrive.

The additive latency is not given as a number. A two-bit mode field picks it relative to the CAS latency: zero, one below CL, or two below CL. Read timing is therefore AL+CL and write timing is AL+CWL. Every accepted command enters one shared shift pipeline, so commands on consecutive clocks can be in flight together and each keeps its own timing. CL, CWL and the AL selector are captured only by a mode-register write. Two sticky flags report a reserved AL selector and a mode-register write made while commands are still in flight.

Top module: `al_cmd_pipe`

## Requirements
- R1: A mode-register write with `mrs_al_sel` (bit 1 = A4, bit 0 = A3) of 2'b00 sets AL to 0, 2'b01 sets AL to CL-1 and 2'b10 sets AL to CL-2, using the CL captured by the same write.
- R2: A command sampled with `cmd_vld` high at clock edge k drives `icmd_vld` high for exactly the one cycle after edge k+AL. With AL = 0 this is the cycle right after acceptance.
- R3: A read (`cmd_wr` = 0) accepted at edge k holds `rd_valid` high for the four cycles that follow edges k+AL+CL through k+AL+CL+3.
- R4: A write (`cmd_wr` = 1) accepted at edge k holds `wr_window` high for the four cycles that follow edges k+AL+CWL through k+AL+CWL+3.
- R5: Commands accepted on consecutive clocks each keep their own issue time and data windows. Overlapping windows merge into a continuous high level.
- R6: `icmd_wr` and `icmd_ap` show the type and auto-precharge tag of the command being issued. An auto-precharge command has the same delay as a plain one.
- R7: Changes on `mrs_cl`, `mrs_cwl` and `mrs_al_sel` while `mrs_we` is low have no effect on timing.
- R8: A mode-register write with `mrs_al_sel` = 2'b11 sets `al_rsvd_err`, which stays set until reset, and makes AL 0.
- R9: A mode-register write accepted while a command has not finished its data window sets `cfg_err`, which stays set until reset. A write with nothing in flight leaves it clear.
- R10: The captured CL is limited to the range 2..MAX_CL (16 by default) and CWL to 1..MAX_CWL (12 by default).
- R11: After reset, all outputs are low and the configuration is CL = 6, CWL = 5, AL = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrs_we | input | 1 | Mode-register write strobe |
| mrs_cl | input | CL_W | CAS latency value |
| mrs_cwl | input | CL_W | CAS write latency value |
| mrs_al_sel | input | 2 | Additive latency selector {A4,A3} |
| cmd_vld | input | 1 | Column command strobe |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_ap | input | 1 | Auto-precharge tag |
| icmd_vld | output | 1 | Internal command launch |
| icmd_wr | output | 1 | Type of launched command |
| icmd_ap | output | 1 | Auto-precharge tag of launched command |
| rd_valid | output | 1 | Read data burst on the bus |
| wr_window | output | 1 | Write data burst expected |
| al_rsvd_err | output | 1 | Sticky: reserved AL selector written |
| cfg_err | output | 1 | Sticky: mode write while busy |

## Verification
The bench drives reads and writes back to back with mixed auto-precharge tags under each AL selector. A design that shared one timer between commands would lose or merge the middle command, and one that dropped the tag would launch it with the wrong flag. It also programs CL and CWL above their limits, which drives the pipeline to its deepest tap, so an undersized delay line would never raise `rd_valid`. Further cases cover the reserved selector, mode inputs that wiggle without a write strobe, and a redundant mode write made just after a read. These catch a flag that is not sticky, AL decoding that ignores the strobe, and an in-flight test that only looks at the issue stage.

// File: rtl/al_pkg.sv
package al_pkg;

  typedef struct packed {
    logic vld;
    logic wr;
    logic ap;
  } al_cmd_t;

  typedef enum logic [1:0] {
    AL_ZERO  = 2'b00,
    AL_CL_M1 = 2'b01,
    AL_CL_M2 = 2'b10,
    AL_RSVD  = 2'b11
  } al_sel_e;

endpackage

// File: rtl/al_rst_sync.sv
module al_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/al_cfg_regs.sv
module al_cfg_regs
  import al_pkg::*;
#(
  parameter int CL_W    = 5,
  parameter int LAT_W   = 5,
  parameter int MAX_CL  = 16,
  parameter int MAX_CWL = 12,
  parameter int RST_CL  = 6,
  parameter int RST_CWL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mrs_we,
  input  logic [CL_W-1:0]  mrs_cl,
  input  logic [CL_W-1:0]  mrs_cwl,
  input  logic [1:0]       mrs_al_sel,
  input  logic             busy,
  output logic [LAT_W-1:0] al,
  output logic [LAT_W-1:0] rl,
  output logic [LAT_W-1:0] wl,
  output logic             rsvd_err,
  output logic             cfg_err
);
  localparam int MIN_CL  = 2;
  localparam int MIN_CWL = 1;

  logic [LAT_W-1:0] cl_q, cwl_q, al_q;
  logic [LAT_W-1:0] cl_d, cwl_d, al_d;
  logic [LAT_W-1:0] cl_c, cwl_c;
  logic             rsvd_q, rsvd_d, cerr_q, cerr_d;
  al_sel_e          sel;

  always_comb begin
    sel = al_sel_e'(mrs_al_sel);
    if (32'(mrs_cl) > MAX_CL)       cl_c = LAT_W'(MAX_CL);
    else if (32'(mrs_cl) < MIN_CL)  cl_c = LAT_W'(MIN_CL);
    else                            cl_c = LAT_W'(mrs_cl);
    if (32'(mrs_cwl) > MAX_CWL)      cwl_c = LAT_W'(MAX_CWL);
    else if (32'(mrs_cwl) < MIN_CWL) cwl_c = LAT_W'(MIN_CWL);
    else                             cwl_c = LAT_W'(mrs_cwl);

    cl_d   = cl_q;
    cwl_d  = cwl_q;
    al_d   = al_q;
    rsvd_d = rsvd_q;
    cerr_d = cerr_q | (mrs_we & busy);
    if (mrs_we) begin
      cl_d  = cl_c;
      cwl_d = cwl_c;
      unique case (sel)
        AL_CL_M1: al_d = cl_c - LAT_W'(1);
        AL_CL_M2: al_d = cl_c - LAT_W'(2);
        AL_RSVD: begin
          al_d   = '0;
          rsvd_d = 1'b1;
        end
        default:  al_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q   <= LAT_W'(RST_CL);
      cwl_q  <= LAT_W'(RST_CWL);
      al_q   <= '0;
      rsvd_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      cl_q   <= cl_d;
      cwl_q  <= cwl_d;
      al_q   <= al_d;
      rsvd_q <= rsvd_d;
      cerr_q <= cerr_d;
    end
  end

  assign al       = al_q;
  assign rl       = cl_q + al_q;
  assign wl       = cwl_q + al_q;
  assign rsvd_err = rsvd_q;
  assign cfg_err  = cerr_q;

  assert_rsvd_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_we && mrs_al_sel == 2'b11) |=> (rsvd_err && al == '0));
  assert_rsvd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_err |=> rsvd_err);
  assert_busy_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_we && busy) |=> cfg_err);
  assert_cfg_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_al_below_cl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    al < cl_q);
endmodule

// File: rtl/al_delay_line.sv
module al_delay_line
  import al_pkg::*;
#(
  parameter int DEPTH = 35
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  al_cmd_t               in_cmd,
  output al_cmd_t [DEPTH-1:0]   st
);
  al_cmd_t [DEPTH-1:0] st_q, st_d;

  always_comb st_d = {st_q[DEPTH-2:0], in_cmd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/al_tap_decode.sv
module al_tap_decode
  import al_pkg::*;
#(
  parameter int DEPTH = 35,
  parameter int LAT_W = 5,
  parameter int BURST = 4
) (
  input  al_cmd_t [DEPTH-1:0] st,
  input  logic [LAT_W-1:0]    al,
  input  logic [LAT_W-1:0]    rl,
  input  logic [LAT_W-1:0]    wl,
  output al_cmd_t             icmd,
  output logic                rd_valid,
  output logic                wr_window,
  output logic                busy
);
  localparam int IW = $clog2(DEPTH);

  logic [IW-1:0] ridx, widx, lim;

  always_comb begin
    icmd      = st[IW'(al)];
    rd_valid  = 1'b0;
    wr_window = 1'b0;
    busy      = 1'b0;
    ridx      = '0;
    widx      = '0;
    lim       = '0;
    for (int j = 0; j < BURST; j++) begin
      ridx = IW'(rl) + IW'(j);
      widx = IW'(wl) + IW'(j);
      if (st[ridx].vld && !st[ridx].wr) rd_valid  = 1'b1;
      if (st[widx].vld &&  st[widx].wr) wr_window = 1'b1;
    end
    for (int j = 0; j < DEPTH; j++) begin
      lim = (st[j].wr ? IW'(wl) : IW'(rl)) + IW'(BURST - 1);
      if (st[j].vld && (IW'(j) <= lim)) busy = 1'b1;
    end
  end
endmodule

// File: rtl/al_cmd_pipe.sv
module al_cmd_pipe
  import al_pkg::*;
#(
  parameter int CL_W    = 5,
  parameter int MAX_CL  = 16,
  parameter int MAX_CWL = 12,
  parameter int RST_CL  = 6,
  parameter int RST_CWL = 5,
  parameter int BURST   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mrs_we,
  input  logic [CL_W-1:0] mrs_cl,
  input  logic [CL_W-1:0] mrs_cwl,
  input  logic [1:0]      mrs_al_sel,
  input  logic            cmd_vld,
  input  logic            cmd_wr,
  input  logic            cmd_ap,
  output logic            icmd_vld,
  output logic            icmd_wr,
  output logic            icmd_ap,
  output logic            rd_valid,
  output logic            wr_window,
  output logic            al_rsvd_err,
  output logic            cfg_err
);
  localparam int LAT_W = $clog2(2 * MAX_CL);
  localparam int DEPTH = 2 * MAX_CL - 1 + BURST;

  logic                rst_n_s;
  logic [LAT_W-1:0]    al, rl, wl;
  logic                busy;
  al_cmd_t             in_cmd, icmd;
  al_cmd_t [DEPTH-1:0] st;

  al_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  al_cfg_regs #(
    .CL_W(CL_W), .LAT_W(LAT_W), .MAX_CL(MAX_CL), .MAX_CWL(MAX_CWL),
    .RST_CL(RST_CL), .RST_CWL(RST_CWL)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mrs_we     (mrs_we),
    .mrs_cl     (mrs_cl),
    .mrs_cwl    (mrs_cwl),
    .mrs_al_sel (mrs_al_sel),
    .busy       (busy),
    .al         (al),
    .rl         (rl),
    .wl         (wl),
    .rsvd_err   (al_rsvd_err),
    .cfg_err    (cfg_err)
  );

  always_comb begin
    in_cmd.vld = cmd_vld;
    in_cmd.wr  = cmd_vld & cmd_wr;
    in_cmd.ap  = cmd_vld & cmd_ap;
  end

  al_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .in_cmd (in_cmd),
    .st     (st)
  );

  al_tap_decode #(.DEPTH(DEPTH), .LAT_W(LAT_W), .BURST(BURST)) u_tap (
    .st        (st),
    .al        (al),
    .rl        (rl),
    .wl        (wl),
    .icmd      (icmd),
    .rd_valid  (rd_valid),
    .wr_window (wr_window),
    .busy      (busy)
  );

  assign icmd_vld = icmd.vld;
  assign icmd_wr  = icmd.wr;
  assign icmd_ap  = icmd.ap;

  assert_zero_al_issue_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(cmd_vld) && !$past(mrs_we) && al == '0) |->
      (icmd_vld && icmd_wr == $past(cmd_wr) && icmd_ap == $past(cmd_ap)));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!$past(cmd_vld) && !$past(mrs_we) && al == '0) |-> !icmd_vld);
endmodule

// File: tb/tb_al_cmd_pipe.sv
module tb_al_cmd_pipe;
  localparam int CLK_P  = 10;
  localparam int NCYC   = 4096;
  localparam int MAXCL  = 16;
  localparam int MAXCWL = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mrs_we;
  logic [4:0] mrs_cl, mrs_cwl;
  logic [1:0] mrs_al_sel;
  logic       cmd_vld, cmd_wr, cmd_ap;
  logic       icmd_vld, icmd_wr, icmd_ap, rd_valid, wr_window, al_rsvd_err, cfg_err;

  al_cmd_pipe dut (
    .clk(clk), .rst_n(rst_n), .mrs_we(mrs_we), .mrs_cl(mrs_cl), .mrs_cwl(mrs_cwl),
    .mrs_al_sel(mrs_al_sel), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_ap(cmd_ap),
    .icmd_vld(icmd_vld), .icmd_wr(icmd_wr), .icmd_ap(icmd_ap), .rd_valid(rd_valid),
    .wr_window(wr_window), .al_rsvd_err(al_rsvd_err), .cfg_err(cfg_err)
  );

  always #(CLK_P / 2) clk = ~clk;

  typedef struct { int cyc; logic wr; logic ap; } exp_t;
  exp_t  q[$];
  logic  exp_rd [NCYC];
  logic  exp_wr [NCYC];
  int    edge_cnt = 0;
  int    n_chk = 0, n_fail = 0;
  logic  mon_on = 1'b0;
  logic  done = 1'b0;
  string phase = "R11";
  int    m_al = 0, m_rl = 6, m_wl = 5;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(string tag, int got, int expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, expv, edge_cnt);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      cmd_vld = 1'b0; cmd_wr = 1'b0; cmd_ap = 1'b0; mrs_we = 1'b0;
    end
  endtask

  // driver: one command per call, captured at the next edge
  task automatic issue(logic wr, logic ap);
    int cap;
    exp_t e;
    @(posedge clk); #1;
    cmd_vld = 1'b1; cmd_wr = wr; cmd_ap = ap;
    cap = edge_cnt + 1;
    e.cyc = cap + m_al; e.wr = wr; e.ap = ap;
    q.push_back(e);
    for (int j = 0; j < 4; j++) begin
      if (wr) exp_wr[cap + m_wl + j] = 1'b1;
      else    exp_rd[cap + m_rl + j] = 1'b1;
    end
  endtask

  task automatic mrs(int cl, int cwl, logic [1:0] sel);
    int c, w;
    @(posedge clk); #1;
    cmd_vld = 1'b0;
    mrs_we = 1'b1; mrs_cl = 5'(cl); mrs_cwl = 5'(cwl); mrs_al_sel = sel;
    c = (cl > MAXCL) ? MAXCL : ((cl < 2) ? 2 : cl);
    w = (cwl > MAXCWL) ? MAXCWL : ((cwl < 1) ? 1 : cwl);
    case (sel)
      2'b01:   m_al = c - 1;
      2'b10:   m_al = c - 2;
      default: m_al = 0;
    endcase
    m_rl = c + m_al;
    m_wl = w + m_al;
    @(posedge clk); #1;
    mrs_we = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (q.size() > 0 && q[0].cyc == edge_cnt) begin
        chk({"R2 issue ", phase}, int'(icmd_vld), 1);
        chk({"R6 wr tag ", phase}, int'(icmd_wr), int'(q[0].wr));
        chk({"R6 ap tag ", phase}, int'(icmd_ap), int'(q[0].ap));
        void'(q.pop_front());
      end else begin
        chk({"R2 no issue ", phase}, int'(icmd_vld), 0);
      end
      chk({"R3 rd_valid ", phase}, int'(rd_valid), int'(exp_rd[edge_cnt]));
      chk({"R4 wr_window ", phase}, int'(wr_window), int'(exp_wr[edge_cnt]));
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < NCYC; i++) begin exp_rd[i] = 1'b0; exp_wr[i] = 1'b0; end
    rst_n = 1'b0; mrs_we = 1'b0; mrs_cl = 5'd6; mrs_cwl = 5'd5; mrs_al_sel = 2'b00;
    cmd_vld = 1'b0; cmd_wr = 1'b0; cmd_ap = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    // R11: reset state
    chk("R11 icmd_vld", int'(icmd_vld), 0);
    chk("R11 rd_valid", int'(rd_valid), 0);
    chk("R11 wr_window", int'(wr_window), 0);
    chk("R11 al_rsvd_err", int'(al_rsvd_err), 0);
    chk("R11 cfg_err", int'(cfg_err), 0);
    mon_on = 1'b1;

    // R11: default CL 6 / CWL 5 / AL 0
    phase = "R11 defaults";
    issue(1'b0, 1'b0); idle(1);
    issue(1'b1, 1'b1); idle(20);

    // R7: mode inputs move without strobe
    phase = "R7 no strobe";
    mrs_cl = 5'd12; mrs_cwl = 5'd9; mrs_al_sel = 2'b01;
    issue(1'b0, 1'b1); idle(20);

    // R1 / R5 / R6: AL = CL-1, back to back mixed
    phase = "R1 R5 AL=CL-1";
    mrs(8, 6, 2'b01);
    issue(1'b0, 1'b0); issue(1'b1, 1'b1); issue(1'b0, 1'b1); issue(1'b0, 1'b0);
    idle(40);

    // R1: AL = CL-2
    phase = "R1 AL=CL-2";
    mrs(10, 7, 2'b10);
    issue(1'b1, 1'b0); issue(1'b0, 1'b1); issue(1'b1, 1'b1);
    idle(45);

    // R10: limits drive the deepest taps
    phase = "R10 clamp";
    mrs(31, 20, 2'b01);
    issue(1'b0, 1'b1); issue(1'b1, 1'b0);
    idle(45);
    @(negedge clk);
    chk("R9 idle mode write leaves cfg_err clear", int'(cfg_err), 0);
    chk("R8 valid selector leaves al_rsvd_err clear", int'(al_rsvd_err), 0);

    // R8: reserved selector
    phase = "R8 reserved";
    mrs(6, 5, 2'b11);
    @(negedge clk);
    chk("R8 al_rsvd_err set", int'(al_rsvd_err), 1);
    issue(1'b0, 1'b0); issue(1'b1, 1'b0); idle(20);
    mrs(6, 5, 2'b00);
    @(negedge clk);
    chk("R8 al_rsvd_err sticky", int'(al_rsvd_err), 1);
    chk("R9 cfg_err still clear", int'(cfg_err), 0);

    // R9: mode write while a read is in flight (same values)
    phase = "R9 busy write";
    issue(1'b0, 1'b0); idle(2);
    mrs(6, 5, 2'b00);
    @(negedge clk);
    chk("R9 cfg_err set", int'(cfg_err), 1);
    idle(20);
    @(negedge clk);
    chk("R9 cfg_err sticky", int'(cfg_err), 1);
    chk("R2 all issues seen", q.size(), 0);

    mon_on = 1'b0;
    report();
  end
endmodule